// File: doc/BRIEF.md
# Link Conditioner Control Register Bank

This block holds the two control bytes of a high-speed link conditioner and turns them into the control signals used by the lane hardware. A byte-wide register port writes and reads the bytes. A link-control byte holds lane swap, lane polarity, forced power-down, the automatic power-down override and the serial bus rate. A mode byte holds the application mode, the hot-plug gate, the two equalizer enables, an apply command and the function mode.

The equalizer enables reach the analog lanes through a shadow stage. A register write changes only the staged copy. The staged copy is committed to the active outputs when a 1 is written to the self-clearing apply bit, and on every clock while the link is idle. The active function mode is loaded only when forced power-down changes or the hot-plug sink input toggles. When the bus-enable strap is low, the swap and polarity fields follow the swap/polarity strap and some fields refuse writes. The bank also drives the hot-plug source output and the power-down state.

Top module: `lcb_cfg_bank`

## Requirements
- R1: A synchronous active-low reset loads the defaults. Register 0x09 reads 0x02 and register 0x0A reads 0x31. Both active equalizer enables are 1 and the active function mode is 2'b01.
- R2: Reads at 0x09 return {swap[7], polarity[6], 00, forced power-down[3], auto-power-down disable[2], rate[1:0]}. Reads at 0x0A return {application mode[7], hot-plug gate[6], adaptive EQ[5], EQ enable[4], 0, 0, function mode[1:0]}. Any other address reads 0x00, and writes to it change nothing.
- R3: While strap_bus_en is low, writes to swap (0x09 bit 7), polarity (0x09 bit 6) and adaptive EQ (0x0A bit 5) are ignored. On every clock in this state, swap and polarity load strap_swap_pol.
- R4: Outside the idle state, a write to EQ enable or adaptive EQ leaves act_eq_en and act_eq_adapt unchanged until an apply is written.
- R5: Writing 0x0A with bit 2 set commits the staged equalizer enables, including the values in that same write, at that clock edge. Bit 2 always reads back 0.
- R6: The link is idle when link_oe is low, hp_sink is low, or forced power-down is set. While it is idle, the staged equalizer enables reach the active outputs at each clock edge without an apply.
- R7: hp_source equals hp_sink when the hot-plug gate bit is 0 and is held at 0 when the gate bit is 1.
- R8: pwr_down is 1 when forced power-down is set, or when hp_sink is low and automatic power-down is not disabled.
- R9: act_func_mode loads the staged function mode only at a clock edge where hp_sink differs from its value at the previous edge, or where forced power-down changes value. A plain write does not move it.
- R10: A write of rate code 2'b11 to 0x09 is rejected when the stored auto-power-down disable bit is 0 before that write. The rate field keeps its value, and the other fields of the write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| acc_addr | input | 8 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for acc_addr (combinational) |
| strap_bus_en | input | 1 | Register bus enable strap; low locks the strapped fields |
| strap_swap_pol | input | 1 | Strap value for lane swap and polarity |
| link_oe | input | 1 | Output enable of the link |
| hp_sink | input | 1 | Hot-plug detect from the sink side |
| hp_source | output | 1 | Hot-plug detect toward the source side |
| pwr_down | output | 1 | Power-down state |
| lane_swap | output | 1 | Lane swap enable |
| lane_pol | output | 1 | Lane polarity inversion |
| bus_rate | output | 2 | Selected serial bus rate code |
| app_mode | output | 1 | Application mode (0 source, 1 sink) |
| act_eq_en | output | 1 | Active equalizer enable |
| act_eq_adapt | output | 1 | Active adaptive equalizer enable |
| act_func_mode | output | 2 | Active function mode |

## Verification
The bench targets four weak points. The first is a staged equalizer write made while the link is active; a design without the shadow stage moves act_eq_en at once. The second is the apply bit written together with new enables; a design that commits the old staged copy lags by one write, and one that stores the bit reads it back as 1. The third is a rate-11 write that also sets the override bit in the same byte; a design that checks the new bit instead of the stored one accepts the rate too early. The bench also makes hot-plug toggles, forced power-down toggles and function-mode writes, so that a design that loads the mode on a write, or misses one of the two load events, goes out of step with the reference model.

// File: rtl/lcb_pkg.sv
// Package: shared field layout and defaults for the link conditioner bank.
// Assumes 8-bit registers; the bit positions are fixed by the register view.
package lcb_pkg;

    typedef struct packed {
        logic       swap;
        logic       pol;
        logic       pd;
        logic       apd_dis;
        logic [1:0] rate;
    } link_ctl_t;

    typedef struct packed {
        logic       app;
        logic       gate;
        logic       adapt;
        logic       eq;
        logic [1:0] fmode;
    } mode_ctl_t;

    localparam logic [1:0] RATE_TOP     = 2'b11;
    localparam link_ctl_t  LINK_DEFAULT = '{swap: 1'b0, pol: 1'b0, pd: 1'b0,
                                            apd_dis: 1'b0, rate: 2'b10};
    localparam mode_ctl_t  MODE_DEFAULT = '{app: 1'b0, gate: 1'b0, adapt: 1'b1,
                                            eq: 1'b1, fmode: 2'b01};
    localparam int         APPLY_BIT    = 2;

endpackage

// File: rtl/lcb_shadow_reg.sv
// Module: generic shadow register. It loads d whenever load is high and
// otherwise holds q. Assumes a synchronous active-low reset to RST_VAL.
module lcb_shadow_reg #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Per-bit hold/load registers, generated so each bit is explicit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Load one bit of the shadow on request.
        always_ff @(posedge clk) begin
            if (!rst_n)    q[b] <= RST_VAL[b];
            else if (load) q[b] <= d[b];
        end
    end

endmodule

// File: rtl/lcb_ctrl_regs.sv
// Module: staged register storage for the link and mode bytes.
// It decodes writes, applies the strap lock and the rate guard, and
// provides the read view. Assumes that writes last one cycle and that
// reads are combinational on acc_addr.
module lcb_ctrl_regs
    import lcb_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LINK = 8'h09,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strap_bus_en,
    input  logic              strap_swap_pol,
    output link_ctl_t         link_q,
    output mode_ctl_t         mode_q,
    output logic              nxt_pd,
    output logic [1:0]        nxt_eq_pair,
    output logic [1:0]        nxt_fmode,
    output logic              apply_stb,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF = DATA_W / 2;

    link_ctl_t link_d;
    mode_ctl_t mode_d;
    logic      wr_link;
    logic      wr_mode;
    logic      rate_ok;

    assign wr_link = wr_en && (acc_addr == ADDR_LINK);
    assign wr_mode = wr_en && (acc_addr == ADDR_MODE);
    // Rate code 11 needs the override bit already stored.
    assign rate_ok = (wr_data[1:0] != RATE_TOP) || link_q.apd_dis;

    // Next value of the link byte: write decode, rate guard, strap lock.
    always_comb begin
        link_d = link_q;
        if (wr_link) begin
            link_d.pd      = wr_data[3];
            link_d.apd_dis = wr_data[2];
            if (rate_ok) link_d.rate = wr_data[1:0];
            if (strap_bus_en) begin
                link_d.swap = wr_data[DATA_W-1];
                link_d.pol  = wr_data[DATA_W-2];
            end
        end
        if (!strap_bus_en) begin
            link_d.swap = strap_swap_pol;
            link_d.pol  = strap_swap_pol;
        end
    end

    // Next value of the mode byte; adaptive EQ is strap-locked.
    always_comb begin
        mode_d = mode_q;
        if (wr_mode) begin
            mode_d.app   = wr_data[DATA_W-1];
            mode_d.gate  = wr_data[DATA_W-2];
            mode_d.eq    = wr_data[HALF];
            mode_d.fmode = wr_data[1:0];
            if (strap_bus_en) mode_d.adapt = wr_data[HALF+1];
        end
    end

    // Storage for both staged bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= LINK_DEFAULT;
            mode_q <= MODE_DEFAULT;
        end else begin
            link_q <= link_d;
            mode_q <= mode_d;
        end
    end

    assign apply_stb   = wr_mode && wr_data[APPLY_BIT];
    assign nxt_pd      = link_d.pd;
    assign nxt_eq_pair = {mode_d.adapt, mode_d.eq};
    assign nxt_fmode   = mode_d.fmode;

    // Read view; reserved and apply positions read as zero.
    always_comb begin
        rd_data = '0;
        if (acc_addr == ADDR_LINK)
            rd_data = {link_q.swap, link_q.pol, 2'b00, link_q.pd,
                       link_q.apd_dis, link_q.rate};
        else if (acc_addr == ADDR_MODE)
            rd_data = {mode_q.app, mode_q.gate, mode_q.adapt, mode_q.eq,
                       2'b00, mode_q.fmode};
    end

endmodule

// File: rtl/lcb_hpd_pm.sv
// Module: hot-plug and power-state logic. It gates hot-plug toward the
// source, forms the power-down state and the idle condition, and flags the
// edges at which the active function mode may reload. Assumes hp_sink is
// already synchronous to clk.
module lcb_hpd_pm (
    input  logic clk,
    input  logic rst_n,
    input  logic hp_sink,
    input  logic link_oe,
    input  logic pd_q,
    input  logic pd_d,
    input  logic apd_dis,
    input  logic gate,
    output logic hp_source,
    output logic pwr_down,
    output logic idle,
    output logic mode_load
);

    logic hp_prev;

    // Remember hp_sink from the last edge for toggle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hp_prev <= 1'b0;
        else        hp_prev <= hp_sink;
    end

    assign hp_source = hp_sink && !gate;
    assign pwr_down  = pd_q || (!hp_sink && !apd_dis);
    assign idle      = !link_oe || !hp_sink || pd_q;
    assign mode_load = (hp_sink != hp_prev) || (pd_d != pd_q);

endmodule

// File: rtl/lcb_cfg_bank.sv
// Module: top of the link conditioner control bank. It joins the staged
// registers, the equalizer and function-mode shadows, and the hot-plug and
// power logic. Assumes single-cycle writes and synchronous active-low reset.
module lcb_cfg_bank
    import lcb_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LINK = 8'h09,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              strap_bus_en,
    input  logic              strap_swap_pol,
    input  logic              link_oe,
    input  logic              hp_sink,
    output logic              hp_source,
    output logic              pwr_down,
    output logic              lane_swap,
    output logic              lane_pol,
    output logic [1:0]        bus_rate,
    output logic              app_mode,
    output logic              act_eq_en,
    output logic              act_eq_adapt,
    output logic [1:0]        act_func_mode
);

    link_ctl_t  link_q;
    mode_ctl_t  mode_q;
    logic       nxt_pd;
    logic [1:0] nxt_eq_pair;
    logic [1:0] nxt_fmode;
    logic       apply_stb;
    logic       idle;
    logic       mode_load;
    logic       pd_q;
    logic       apd_dis_q;
    logic [1:0] eq_pair_q;

    lcb_ctrl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_LINK(ADDR_LINK), .ADDR_MODE(ADDR_MODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
        .wr_data(wr_data), .strap_bus_en(strap_bus_en),
        .strap_swap_pol(strap_swap_pol), .link_q(link_q), .mode_q(mode_q),
        .nxt_pd(nxt_pd), .nxt_eq_pair(nxt_eq_pair), .nxt_fmode(nxt_fmode),
        .apply_stb(apply_stb), .rd_data(rd_data)
    );

    assign pd_q      = link_q.pd;
    assign apd_dis_q = link_q.apd_dis;

    lcb_hpd_pm u_hpd (
        .clk(clk), .rst_n(rst_n), .hp_sink(hp_sink), .link_oe(link_oe),
        .pd_q(pd_q), .pd_d(nxt_pd), .apd_dis(apd_dis_q), .gate(mode_q.gate),
        .hp_source(hp_source), .pwr_down(pwr_down), .idle(idle),
        .mode_load(mode_load)
    );

    lcb_shadow_reg #(.W(2), .RST_VAL({MODE_DEFAULT.adapt, MODE_DEFAULT.eq})) u_eq_shadow (
        .clk(clk), .rst_n(rst_n), .load(idle || apply_stb),
        .d(nxt_eq_pair), .q(eq_pair_q)
    );

    lcb_shadow_reg #(.W(2), .RST_VAL(MODE_DEFAULT.fmode)) u_mode_shadow (
        .clk(clk), .rst_n(rst_n), .load(mode_load),
        .d(nxt_fmode), .q(act_func_mode)
    );

    assign act_eq_adapt = eq_pair_q[1];
    assign act_eq_en    = eq_pair_q[0];
    assign lane_swap    = link_q.swap;
    assign lane_pol     = link_q.pol;
    assign bus_rate     = link_q.rate;
    assign app_mode     = mode_q.app;

endmodule

// File: rtl/lcb_cfg_bank_chk.sv
// Module: property checker for lcb_cfg_bank, attached by bind below.
// Assumes the same synchronous active-low reset as the bank.
module lcb_cfg_bank_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LINK = 8'h09,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic              strap_bus_en,
    input logic              strap_swap_pol,
    input logic              hp_sink,
    input logic              hp_source,
    input logic              pwr_down,
    input logic              lane_swap,
    input logic [1:0]        bus_rate,
    input logic              act_eq_en,
    input logic              act_eq_adapt,
    input logic              forced_pd,
    input logic              apd_dis,
    input logic              link_idle
);

    assert_strap_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_bus_en |=> (lane_swap == $past(strap_swap_pol)));

    assert_eq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_idle && !(wr_en && acc_addr == ADDR_MODE && wr_data[2]))
        |=> $stable({act_eq_en, act_eq_adapt}));

    assert_apply_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == ADDR_MODE) |-> !rd_data[2]);

    assert_hp_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_sink |-> !hp_source);

    assert_forced_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        forced_pd |-> pwr_down);

    assert_rate_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_addr == ADDR_LINK && wr_data[1:0] == 2'b11 && !apd_dis)
        |=> $stable(bus_rate));

endmodule

bind lcb_cfg_bank lcb_cfg_bank_chk #(
    .ADDR_W(ADDR_W), .ADDR_LINK(ADDR_LINK), .ADDR_MODE(ADDR_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
    .wr_data(wr_data), .rd_data(rd_data), .strap_bus_en(strap_bus_en),
    .strap_swap_pol(strap_swap_pol), .hp_sink(hp_sink), .hp_source(hp_source),
    .pwr_down(pwr_down), .lane_swap(lane_swap), .bus_rate(bus_rate),
    .act_eq_en(act_eq_en), .act_eq_adapt(act_eq_adapt), .forced_pd(pd_q),
    .apd_dis(apd_dis_q), .link_idle(idle)
);

// File: tb/lcb_cfg_bank_tb.sv
// Bench: a behavioural reference model, updated at each rising edge and
// compared with every output at each falling edge. Inputs change 1 ns after
// the falling edge.
module lcb_cfg_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       strap_bus_en = 1'b1;
    logic       strap_swap_pol = 1'b0;
    logic       link_oe = 1'b1;
    logic       hp_sink = 1'b1;
    logic       hp_source, pwr_down, lane_swap, lane_pol, app_mode;
    logic       act_eq_en, act_eq_adapt;
    logic [1:0] bus_rate, act_func_mode;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    lcb_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
        .wr_data(wr_data), .rd_data(rd_data), .strap_bus_en(strap_bus_en),
        .strap_swap_pol(strap_swap_pol), .link_oe(link_oe), .hp_sink(hp_sink),
        .hp_source(hp_source), .pwr_down(pwr_down), .lane_swap(lane_swap),
        .lane_pol(lane_pol), .bus_rate(bus_rate), .app_mode(app_mode),
        .act_eq_en(act_eq_en), .act_eq_adapt(act_eq_adapt),
        .act_func_mode(act_func_mode)
    );

    // Reference model state.
    int m_swap, m_pol, m_pd, m_apd, m_rate, m_app, m_gate, m_adapt, m_eq, m_mode;
    int a_eq, a_adapt, a_mode, m_hpq;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read(int addr);
        if (addr == 'h09) return (m_swap << 7) | (m_pol << 6) | (m_pd << 3) | (m_apd << 2) | m_rate;
        if (addr == 'h0A) return (m_app << 7) | (m_gate << 6) | (m_adapt << 5) | (m_eq << 4) | m_mode;
        return 0;
    endfunction

    // Reference model: next state from the requirements, one edge at a time.
    always @(posedge clk) begin
        int n_swap, n_pol, n_pd, n_apd, n_rate, n_app, n_gate, n_adapt, n_eq, n_mode;
        bit apply, idle;
        if (!rst_n) begin
            m_swap = 0; m_pol = 0; m_pd = 0; m_apd = 0; m_rate = 2;
            m_app = 0; m_gate = 0; m_adapt = 1; m_eq = 1; m_mode = 1;
            a_eq = 1; a_adapt = 1; a_mode = 1; m_hpq = 0;
        end else begin
            n_swap = m_swap; n_pol = m_pol; n_pd = m_pd; n_apd = m_apd; n_rate = m_rate;
            n_app = m_app; n_gate = m_gate; n_adapt = m_adapt; n_eq = m_eq; n_mode = m_mode;
            if (wr_en && acc_addr == 8'h09) begin
                n_pd = wr_data[3]; n_apd = wr_data[2];
                if (!(wr_data[1:0] == 2'b11 && m_apd == 0)) n_rate = wr_data[1:0];
                if (strap_bus_en) begin n_swap = wr_data[7]; n_pol = wr_data[6]; end
            end
            if (wr_en && acc_addr == 8'h0A) begin
                n_app = wr_data[7]; n_gate = wr_data[6]; n_eq = wr_data[4];
                n_mode = wr_data[1:0];
                if (strap_bus_en) n_adapt = wr_data[5];
            end
            if (!strap_bus_en) begin n_swap = strap_swap_pol; n_pol = strap_swap_pol; end
            apply = wr_en && acc_addr == 8'h0A && wr_data[2];
            idle  = !link_oe || !hp_sink || (m_pd != 0);
            if (apply || idle) begin a_eq = n_eq; a_adapt = n_adapt; end
            if ((hp_sink != m_hpq) || (n_pd != m_pd)) a_mode = n_mode;
            m_hpq = hp_sink;
            m_swap = n_swap; m_pol = n_pol; m_pd = n_pd; m_apd = n_apd; m_rate = n_rate;
            m_app = n_app; m_gate = n_gate; m_adapt = n_adapt; m_eq = n_eq; m_mode = n_mode;
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 rd_data", rd_data, model_read(acc_addr));
            chk("R3 lane_swap", lane_swap, m_swap);
            chk("R3 lane_pol", lane_pol, m_pol);
            chk("R4 act_eq_en", act_eq_en, a_eq);
            chk("R4 act_eq_adapt", act_eq_adapt, a_adapt);
            chk("R7 hp_source", hp_source, hp_sink && (m_gate == 0));
            chk("R8 pwr_down", pwr_down, (m_pd != 0) || (!hp_sink && m_apd == 0));
            chk("R9 act_func_mode", act_func_mode, a_mode);
            chk("R10 bus_rate", bus_rate, m_rate);
            chk("R2 app_mode", app_mode, m_app);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; acc_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step();
        // R1: defaults after reset.
        acc_addr = 8'h09; #1; chk("R1 reset 09", rd_data, 8'h02);
        acc_addr = 8'h0A; #1; chk("R1 reset 0A", rd_data, 8'h31);
        chk("R1 reset act_func_mode", act_func_mode, 1);
        chk("R1 reset act_eq", {act_eq_adapt, act_eq_en}, 3);
        step();
        // R4: staged write while active does not move outputs.
        wr(8'h0A, 8'h01);
        step();
        chk("R4 eq held", act_eq_en, 1);
        // R5: apply with new data commits it; bit reads 0.
        wr(8'h0A, 8'h25);
        chk("R5 apply commit", act_eq_en, 0);
        acc_addr = 8'h0A; #1; chk("R5 apply reads 0", rd_data[2], 0);
        // R6: idle via link_oe low passes staged values directly.
        link_oe = 1'b0;
        wr(8'h0A, 8'h11);
        chk("R6 idle bypass eq", act_eq_en, 1);
        chk("R6 idle bypass adapt", act_eq_adapt, 0);
        link_oe = 1'b1;
        step();
        // R9: mode write alone does not load; hp toggle does.
        wr(8'h0A, 8'h33);
        step();
        chk("R9 mode held", act_func_mode, 1);
        hp_sink = 1'b0; step();
        chk("R9 mode loaded on toggle", act_func_mode, 3);
        hp_sink = 1'b1; step();
        // R7: gate on blocks hot-plug.
        wr(8'h0A, 8'h73);
        chk("R7 gated", hp_source, 0);
        wr(8'h0A, 8'h33);
        // R10: rate 11 rejected until override is stored.
        wr(8'h09, 8'h03);
        chk("R10 reject", bus_rate, 2);
        wr(8'h09, 8'h07);
        chk("R10 reject same write", bus_rate, 2);
        wr(8'h09, 8'h07);
        chk("R10 accept", bus_rate, 3);
        // R3: strap lock.
        strap_bus_en = 1'b0; strap_swap_pol = 1'b1; step();
        wr(8'h09, 8'h03);
        chk("R3 swap follows strap", lane_swap, 1);
        wr(8'h0A, 8'h03);
        acc_addr = 8'h0A; #1; chk("R3 adapt locked", rd_data[5], 1);
        strap_bus_en = 1'b1; step();
        // R8: forced power-down.
        wr(8'h09, 8'h08);
        chk("R8 forced pd", pwr_down, 1);
        wr(8'h09, 8'h00);
        // R2: other address ignored.
        wr(8'h0B, 8'hFF);
        acc_addr = 8'h0B; #1; chk("R2 other addr", rd_data, 0);
        acc_addr = 8'h09; #1; chk("R2 09 untouched", rd_data, 8'h00);
        // Random traffic against the model.
        for (int i = 0; i < 2000; i++) begin
            int sel = $urandom_range(0, 2);
            wr_en    = ($urandom_range(0, 2) == 0);
            acc_addr = (sel == 0) ? 8'h09 : (sel == 1) ? 8'h0A : 8'h0B;
            wr_data  = 8'($urandom);
            if ($urandom_range(0, 7) == 0) hp_sink = ~hp_sink;
            if ($urandom_range(0, 7) == 0) link_oe = ~link_oe;
            if ($urandom_range(0, 15) == 0) strap_bus_en = ~strap_bus_en;
            if ($urandom_range(0, 7) == 0) strap_swap_pol = ~strap_swap_pol;
            step();
        end
        wr_en = 1'b0;
        step();
        summary();
    end

endmodule